// File: doc/BRIEF.md
# Shortened Reed-Solomon Encoder

This block is a systematic Reed-Solomon encoder over GF(2^8). It is built on the (255,239) mother code, which has sixteen check symbols, and it can be set at run time to one of several shorter profiles. A shortened profile leaves out the leading message bytes: they count as zeros and are never clocked in. A punctured profile keeps only part of the sixteen check symbols. Message bytes arrive one per clock through a valid/ready handshake. A parity register, whose constant multipliers are set by the generator polynomial, updates once for each accepted byte.

The block holds the information bytes of a block in a local buffer until the parity is complete. It then emits the coded block with the parity bytes first and the information bytes after them. Every output symbol is flagged valid, and the last one is marked. While the block is emitting, its input stays closed, so the source stalls and loses no byte. It reopens on the clock after the final symbol.

Top module: `rs_shortened_encoder`

## Requirements
- R1: After synchronous reset, `in_ready` is 1 and `out_valid` is 0.
- R2: `prof_sel` picks the (n,k,t) profile: 0 = (255,239,8), 1 = (12,12,0), 2 = (32,24,4), 3 = (40,36,2). The number of parity bytes sent is 2t = n-k. The select is sampled on the clock that accepts the first byte of a block.
- R3: A byte is taken only on a clock where `in_valid` and `in_ready` are both 1. Exactly k bytes are taken per block. `in_ready` is 0 from the k-th acceptance until the last output symbol, and input presented during that time is ignored.
- R4: Each block produces exactly n symbols, with `out_valid` held high without gaps. `out_last` is 1 only on the n-th symbol.
- R5: The first n-k output symbols are parity. The k information bytes follow them, in the order they arrived.
- R6: The parity is the remainder of m(x)*x^16 divided by g(x) = (x+a^0)(x+a^1)...(x+a^15). The field polynomial is x^8+x^4+x^3+x^2+1 and a = 0x02. The first message byte is the highest-degree coefficient of m(x). Remainder coefficients are emitted highest degree first.
- R7: A punctured profile sends only the first 2t of the sixteen remainder symbols, in the order of R6.
- R8: With t = 0, the output block is the k input bytes, unchanged, with no parity.
- R9: `in_ready` is 1 on the clock after `out_last`, so a new block can start there.
- R10: Idle cycles on `in_valid` between message bytes do not change the coded output.
- R11: A change of `prof_sel` after the first byte of a block is accepted has no effect on that block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prof_sel | input | 2 | Profile select, sampled at the first byte of a block |
| in_valid | input | 1 | Message byte present |
| in_data | input | 8 | Message byte |
| in_ready | output | 1 | Encoder can take a message byte |
| out_valid | output | 1 | Output symbol valid |
| out_data | output | 8 | Coded symbol (parity first, then information) |
| out_last | output | 1 | Final symbol of the coded block |

## Verification
Every profile is driven with five message patterns. An all-zero message must give zero parity. All-0xFF and ramp messages exercise every multiplier tap. A pseudo-random message is checked against a long-division model, and for the full profile its codeword must also vanish at all sixteen generator roots, which is independent of any division. A single nonzero leading byte separates an error in one generator coefficient from an ordering error. Some runs add idle input cycles, some present stray bytes during emission, and some change the select in mid-block, so that R10, R3 and R11 show up as miscompares whenever they are broken.

// File: rtl/rs_enc_pkg.sv
`timescale 1ns/1ps
package rs_enc_pkg;

    localparam int SYM_W      = 8;
    localparam int NPAR_MAX   = 16;
    localparam int K_MOTHER   = 239;
    localparam int CNT_W      = $clog2(K_MOTHER + 1);
    localparam int PAR_W      = $clog2(NPAR_MAX + 1);
    localparam logic [SYM_W:0] FIELD_POLY = 9'h11D;

    typedef logic [SYM_W-1:0] sym_t;
    typedef sym_t [NPAR_MAX-1:0] gen_t;

    typedef struct packed {
        logic [CNT_W-1:0] k;
        logic [PAR_W-1:0] npar;
    } prof_t;

    typedef enum logic [1:0] {
        ST_LOAD   = 2'd0,
        ST_PARITY = 2'd1,
        ST_DATA   = 2'd2
    } enc_state_t;

    function automatic sym_t gf_mul(input sym_t a, input sym_t b);
        sym_t acc;
        sym_t x;
        acc = '0;
        x   = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc = acc ^ x;
            if (x[SYM_W-1]) x = {x[SYM_W-2:0], 1'b0} ^ FIELD_POLY[SYM_W-1:0];
            else            x = {x[SYM_W-2:0], 1'b0};
        end
        return acc;
    endfunction

    // Low coefficients of the monic generator with roots a^0 .. a^(NPAR_MAX-1).
    function automatic gen_t rs_gen_poly();
        sym_t c [NPAR_MAX+1];
        sym_t root;
        gen_t g;
        for (int d = 0; d <= NPAR_MAX; d++) c[d] = '0;
        c[0] = sym_t'(1);
        root = sym_t'(1);
        for (int i = 0; i < NPAR_MAX; i++) begin
            for (int d = NPAR_MAX; d >= 1; d--) c[d] = c[d-1] ^ gf_mul(c[d], root);
            c[0] = gf_mul(c[0], root);
            root = gf_mul(root, sym_t'(2));
        end
        for (int d = 0; d < NPAR_MAX; d++) g[d] = c[d];
        return g;
    endfunction

    function automatic prof_t prof_lookup(input logic [1:0] sel);
        prof_t p;
        case (sel)
            2'd1:    begin p.k = CNT_W'(12);       p.npar = PAR_W'(0); end
            2'd2:    begin p.k = CNT_W'(24);       p.npar = PAR_W'(8); end
            2'd3:    begin p.k = CNT_W'(36);       p.npar = PAR_W'(4); end
            default: begin p.k = CNT_W'(K_MOTHER); p.npar = PAR_W'(NPAR_MAX); end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/rs_parity_lfsr.sv
`timescale 1ns/1ps
module rs_parity_lfsr
    import rs_enc_pkg::*;
#(
    parameter int NPAR = NPAR_MAX
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic feed,
    input  logic shift,
    input  sym_t din,
    output sym_t par_top
);
    localparam gen_t GEN = rs_gen_poly();

    sym_t par_q [NPAR];
    sym_t par_d [NPAR];
    sym_t fb;

    assign fb      = din ^ par_q[NPAR-1];
    assign par_top = par_q[NPAR-1];

    for (genvar i = 0; i < NPAR; i++) begin : g_stage
        sym_t below;
        if (i == 0) begin : g_first
            assign below = '0;
        end else begin : g_rest
            assign below = par_q[i-1];
        end

        always_comb begin
            if (clear)      par_d[i] = '0;
            else if (feed)  par_d[i] = below ^ gf_mul(fb, GEN[i]);
            else if (shift) par_d[i] = below;
            else            par_d[i] = par_q[i];
        end

        always_ff @(posedge clk) begin
            if (rst) par_q[i] <= '0;
            else     par_q[i] <= par_d[i];
        end
    end
endmodule

// File: rtl/rs_msg_buffer.sv
`timescale 1ns/1ps
module rs_msg_buffer
    import rs_enc_pkg::*;
#(
    parameter int DEPTH = K_MOTHER,
    parameter int AW    = CNT_W
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  sym_t          wdata,
    input  logic [AW-1:0] raddr,
    output sym_t          rdata
);
    sym_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/rs_seq_ctrl.sv
`timescale 1ns/1ps
module rs_seq_ctrl
    import rs_enc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  prof_t            prof,
    output logic             in_ready,
    output logic             accept,
    output logic             emit_par,
    output logic             emit_dat,
    output logic             last_sym,
    output logic [CNT_W-1:0] cnt
);
    enc_state_t       st_q;
    logic [CNT_W-1:0] k_end;
    logic [CNT_W-1:0] par_end;

    assign k_end    = prof.k - CNT_W'(1);
    assign par_end  = CNT_W'(prof.npar) - CNT_W'(1);
    assign in_ready = (st_q == ST_LOAD);
    assign accept   = in_ready && in_valid;
    assign emit_par = (st_q == ST_PARITY);
    assign emit_dat = (st_q == ST_DATA);
    assign last_sym = emit_dat && (cnt == k_end);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_LOAD;
            cnt  <= '0;
        end else begin
            case (st_q)
                ST_LOAD: if (accept) begin
                    if (cnt == k_end) begin
                        cnt  <= '0;
                        st_q <= (prof.npar == '0) ? ST_DATA : ST_PARITY;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_PARITY: begin
                    if (cnt == par_end) begin
                        cnt  <= '0;
                        st_q <= ST_DATA;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_DATA: begin
                    if (cnt == k_end) begin
                        cnt  <= '0;
                        st_q <= ST_LOAD;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: begin
                    cnt  <= '0;
                    st_q <= ST_LOAD;
                end
            endcase
        end
    end
endmodule

// File: rtl/rs_shortened_encoder.sv
`timescale 1ns/1ps
module rs_shortened_encoder
    import rs_enc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] prof_sel,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       in_ready,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_last
);
    prof_t            prof_q;
    prof_t            prof_eff;
    logic             accept;
    logic             emit_par;
    logic             emit_dat;
    logic [CNT_W-1:0] cnt;
    sym_t             par_top;
    sym_t             buf_rd;

    // The profile follows the select until the first byte of a block is taken.
    assign prof_eff = (in_ready && cnt == '0) ? prof_lookup(prof_sel) : prof_q;

    always_ff @(posedge clk) begin
        if (rst) prof_q <= prof_lookup(2'd0);
        else     prof_q <= prof_eff;
    end

    rs_seq_ctrl i_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .prof     (prof_eff),
        .in_ready (in_ready),
        .accept   (accept),
        .emit_par (emit_par),
        .emit_dat (emit_dat),
        .last_sym (out_last),
        .cnt      (cnt)
    );

    rs_parity_lfsr #(.NPAR(NPAR_MAX)) i_lfsr (
        .clk     (clk),
        .rst     (rst),
        .clear   (out_last),
        .feed    (accept),
        .shift   (emit_par),
        .din     (in_data),
        .par_top (par_top)
    );

    rs_msg_buffer #(.DEPTH(K_MOTHER), .AW(CNT_W)) i_buf (
        .clk   (clk),
        .we    (accept),
        .waddr (cnt),
        .wdata (in_data),
        .raddr (cnt),
        .rdata (buf_rd)
    );

    assign out_valid = emit_par || emit_dat;
    assign out_data  = emit_par ? par_top : (emit_dat ? buf_rd : '0);
endmodule

// File: rtl/rs_enc_checker.sv
`timescale 1ns/1ps
module rs_enc_checker (
    input logic clk,
    input logic rst,
    input logic in_ready,
    input logic out_valid,
    input logic out_last
);
    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (in_ready && !out_valid));

    assert_closed_while_emitting_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    assert_last_is_valid_R4: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    assert_no_gap_in_block_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |=> out_valid);

    assert_reopen_after_last_R9: assert property (@(posedge clk) disable iff (rst)
        out_last |=> (in_ready && !out_valid));
endmodule

bind rs_shortened_encoder rs_enc_checker i_rs_enc_checker (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_last  (out_last)
);

// File: tb/test_rs_shortened_encoder.sv
`timescale 1ns/1ps
module test_rs_shortened_encoder;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] prof_sel;
    logic       in_valid;
    logic [7:0] in_data;
    logic       in_ready;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_last;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [7:0] msg  [239];
    logic [7:0] expv [255];
    logic [7:0] got  [255];
    logic [7:0] gtb  [17];
    logic [7:0] remv [255];
    logic [31:0] seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    rs_shortened_encoder i_rs_shortened_encoder (
        .clk(clk), .rst(rst), .prof_sel(prof_sel),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: got %0d cycles expected under 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    function automatic logic [7:0] xtime(input logic [7:0] v);
        return v[7] ? ({v[6:0], 1'b0} ^ 8'h1D) : {v[6:0], 1'b0};
    endfunction

    function automatic logic [7:0] tb_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            acc = xtime(acc);
            if (b[i]) acc = acc ^ a;
        end
        return acc;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expd);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, expd);
        end
    endtask

    // R2 profile table as seen by the bench
    task automatic prof_of(input int sel, output int k, output int np);
        case (sel)
            1:       begin k = 12;  np = 0;  end
            2:       begin k = 24;  np = 8;  end
            3:       begin k = 36;  np = 4;  end
            default: begin k = 239; np = 16; end
        endcase
    endtask

    task automatic build_gen();
        logic [7:0] root = 8'h01;
        for (int d = 0; d < 17; d++) gtb[d] = 8'h00;
        gtb[0] = 8'h01;
        for (int i = 0; i < 16; i++) begin
            for (int d = 16; d >= 1; d--) gtb[d] = gtb[d-1] ^ tb_mul(gtb[d], root);
            gtb[0] = tb_mul(gtb[0], root);
            root   = tb_mul(root, 8'h02);
        end
    endtask

    task automatic fill_msg(input int k, input int pat);
        for (int i = 0; i < k; i++) begin
            case (pat)
                0: msg[i] = 8'h00;
                1: msg[i] = 8'(i + 1);
                2: msg[i] = 8'hFF;
                3: begin seed = seed * 32'd1103515245 + 32'd12345; msg[i] = seed[23:16]; end
                default: msg[i] = (i == 0) ? 8'h01 : 8'h00;
            endcase
        end
    endtask

    // Long division of m(x)*x^16 by g(x); R6, R7, R5 expected block
    task automatic make_expected(input int k, input int np);
        for (int i = 0; i < k; i++) remv[i] = msg[i];
        for (int i = 0; i < 16; i++) remv[k+i] = 8'h00;
        for (int i = 0; i < k; i++) begin
            logic [7:0] coef = remv[i];
            for (int j = 1; j <= 16; j++) remv[i+j] = remv[i+j] ^ tb_mul(coef, gtb[16-j]);
        end
        for (int i = 0; i < np; i++) expv[i] = remv[k+i];
        for (int i = 0; i < k; i++) expv[np+i] = msg[i];
    endtask

    task automatic run_block(input int sel, input int pat, input bit gaps,
                             input bit junk, input bit wiggle);
        int  k, np, n, sent, outn, cyc;
        bit  pend, done;
        prof_of(sel, k, np);
        n = k + np;
        fill_msg(k, pat);
        make_expected(k, np);
        sent = 0; outn = 0; cyc = 0; pend = 0; done = 0;
        while (!done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            if (pend) sent++;
            if (out_valid) begin
                if (outn < n) begin
                    got[outn] = out_data;
                    chk(out_data == expv[outn],
                        (outn < np) ? "R6/R7 parity" : (np == 0 ? "R8 pass-through" : "R5 info order"),
                        out_data, expv[outn]);
                end
                chk(!in_ready, "R3 input closed during emission", in_ready, 0);
                if (out_last) begin
                    chk(outn == n - 1, "R4 block length", outn + 1, n);
                    done = 1;
                end
                outn++;
            end
            prof_sel = (wiggle && sent > 0) ? 2'(~sel) : 2'(sel);
            if (sent < k) begin
                in_valid = !(gaps && (cyc % 3 == 0));
                in_data  = msg[sent];
            end else begin
                in_valid = junk && out_valid && !out_last;
                in_data  = 8'hA5;
            end
            pend = in_valid && in_ready;
        end
        chk(done, "R4 out_last seen", done, 1);
        chk(sent == k, "R3 bytes accepted", sent, k);
        if (sel == 0 && done) begin
            // Codeword vanishes at all generator roots (R6)
            logic [7:0] a = 8'h01;
            for (int j = 0; j < 16; j++) begin
                logic [7:0] s = 8'h00;
                for (int i = 0; i < k; i++) s = tb_mul(s, a) ^ got[16+i];
                for (int i = 0; i < 16; i++) s = tb_mul(s, a) ^ got[i];
                chk(s == 8'h00, "R6 syndrome", s, 0);
                a = tb_mul(a, 8'h02);
            end
        end
        @(negedge clk);
        chk(in_ready && !out_valid, "R9 reopen after block", {in_ready, out_valid}, 2);
        in_valid = 1'b0;
    endtask

    initial begin
        rst = 1'b1; prof_sel = 2'd0; in_valid = 1'b0; in_data = 8'h00;
        build_gen();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1 reset in_ready", in_ready, 1);
        chk(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
        // R2 all profiles; R10 gaps on odd patterns; R3 junk on pattern 3; R11 wiggle on pattern 4
        for (int sel = 0; sel < 4; sel++) begin
            for (int pat = 0; pat < 5; pat++) begin
                run_block(sel, pat, pat % 2 == 1, pat == 3, pat == 4);
            end
        end
        // back-to-back profile switch between blocks
        run_block(3, 3, 1'b0, 1'b1, 1'b1);
        run_block(0, 3, 1'b1, 1'b0, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule